// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block collects level-sensitive interrupt lines from on-chip peripherals and presents them to a host processor as one request line, with a programmable host level. The host enables individual lines through a mask register, turns the whole block on through a global enable in the configuration register, and fetches a vector with a two-step handshake. It first writes an acknowledge bit to the vector register. It then reads the same register, which holds the number of the chosen source in its upper five bits. The acknowledge marks that source as in service, so the same line is not offered again until the host writes a one to its in-service bit.

The highest-numbered source that is pending, unmasked and not in service wins. The host can see a request and then find that its line has dropped or been masked before the acknowledge. In that case the acknowledge returns vector 0, marks nothing in service and raises a separate error request. The host dismisses that request by writing a one to in-service bit 0.

The register port is a plain single-cycle interface. A write takes effect at the clock edge where `reg_wr_i` is high. Read data is combinational from `reg_addr_i`. Word addresses are: 0 configuration, 1 pending, 2 mask, 3 in-service, 4 vector. Other addresses read as zero.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset the configuration, mask, in-service and latched vector registers read zero, and `irq_o` and `err_irq_o` are low.
- R2: Mask bit i (address 2) set to 1 enables source i. A source whose mask bit is 0 never drives `irq_o` and is never chosen by an acknowledge.
- R3: While configuration bit 0 (global enable) is 0, `irq_o` stays low whatever the sources and masks are.
- R4: Configuration bits 15:13 drive `irq_level_o` from the edge after the write, and the configuration register reads back the written bits 15:13 and bit 0.
- R5: Writing the vector register (address 4) with bit 0 = 1 latches the highest-numbered eligible source. A following read returns that number in bits 15:11, with all other bits zero. Eligible means pending, unmasked and not in service.
- R6: The same acknowledge edge sets the chosen source's in-service bit. A source whose in-service bit is set is not chosen again, so the next acknowledge returns the next lower eligible source.
- R7: Writing the in-service register (address 3) clears every bit written as 1. Bits written as 0 keep their value.
- R8: An acknowledge with no eligible source latches vector 0, sets no in-service bit and raises `err_irq_o`. `err_irq_o` stays high until an in-service write with bit 0 = 1.
- R9: With the global enable set, `irq_o` is high exactly when at least one source is eligible.
- R10: A vector register write with bit 0 = 0 changes neither the latched vector nor the in-service register.
- R11: The pending register (address 1) reads the current source levels, whatever the mask is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Request to host |
| irq_level_o | output | 3 | Selected host interrupt level |
| err_irq_o | output | 1 | Error request after an empty acknowledge |

## Verification
The hardest case to reach is the race: `irq_o` goes high, and then the line vanishes before the host acknowledges. The bench raises one source, confirms the request, drops the line, and only then issues the acknowledge. It expects vector 0, an unchanged in-service register and a raised error request. It also drains a set of three sources down to an empty acknowledge. This shows that the error path is reached the same way once in-service bits hide every line, and that source 0 as a real line is kept apart from the error vector.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  typedef enum logic [2:0] {
    A_CFG  = 3'd0,
    A_PEND = 3'd1,
    A_MASK = 3'd2,
    A_INSV = 3'd3,
    A_VEC  = 3'd4
  } vpic_addr_e;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_LVL_LSB = 13;
  localparam int VEC_ACK_BIT = 0;
  localparam int VEC_NUM_LSB = 11;
  localparam int VEC_FIELD_W = 5;
endpackage

// File: rtl/vpic_prio.sv
module vpic_prio #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vpic_isr.sv
module vpic_isr #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [N-1:0]     clr_i,
  output logic [N-1:0]     q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q_o[g] <= 1'b0;
      else if (set_i && set_idx_i == IDX_W'(g))  q_o[g] <= 1'b1;
      else if (clr_i[g])                         q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o,
  output logic [2:0]         irq_level_o,
  output logic               err_irq_o
);
  import vpic_pkg::*;
  localparam int VEC_W = $clog2(NUM_SRC);

  logic               cfg_en_q;
  logic [2:0]         cfg_lvl_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] insv_q;
  logic [VEC_W-1:0]   vec_q;
  logic               err_q;

  logic [NUM_SRC-1:0] elig;
  logic               elig_any;
  logic [VEC_W-1:0]   elig_idx;
  logic               ack, wr_cfg, wr_mask, wr_insv;
  logic [NUM_SRC-1:0] insv_clr;

  assign wr_cfg  = reg_wr_i && reg_addr_i == A_CFG;
  assign wr_mask = reg_wr_i && reg_addr_i == A_MASK;
  assign wr_insv = reg_wr_i && reg_addr_i == A_INSV;
  assign ack     = reg_wr_i && reg_addr_i == A_VEC && reg_wdata_i[VEC_ACK_BIT];

  assign elig = src_i & mask_q & ~insv_q;

  vpic_prio #(.N(NUM_SRC), .IDX_W(VEC_W)) u_prio (
    .req_i (elig),
    .any_o (elig_any),
    .idx_o (elig_idx)
  );

  assign insv_clr = wr_insv ? reg_wdata_i[NUM_SRC-1:0] : '0;

  vpic_isr #(.N(NUM_SRC), .IDX_W(VEC_W)) u_isr (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (ack && elig_any),
    .set_idx_i (elig_idx),
    .clr_i     (insv_clr),
    .q_o       (insv_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en_q  <= 1'b0;
      cfg_lvl_q <= '0;
      mask_q    <= '0;
      vec_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_en_q  <= reg_wdata_i[CFG_EN_BIT];
        cfg_lvl_q <= reg_wdata_i[CFG_LVL_LSB +: 3];
      end
      if (wr_mask) mask_q <= reg_wdata_i[NUM_SRC-1:0];
      if (ack) begin
        vec_q <= elig_any ? elig_idx : '0;
        if (!elig_any) err_q <= 1'b1;
      end else if (wr_insv && reg_wdata_i[0]) begin
        err_q <= 1'b0;
      end
    end
  end

  logic [31:0] src_ext, mask_ext, insv_ext;
  always_comb begin
    src_ext  = '0;
    mask_ext = '0;
    insv_ext = '0;
    src_ext[NUM_SRC-1:0]  = src_i;
    mask_ext[NUM_SRC-1:0] = mask_q;
    insv_ext[NUM_SRC-1:0] = insv_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CFG: begin
        reg_rdata_o[CFG_EN_BIT]           = cfg_en_q;
        reg_rdata_o[CFG_LVL_LSB +: 3]     = cfg_lvl_q;
      end
      A_PEND:  reg_rdata_o = src_ext;
      A_MASK:  reg_rdata_o = mask_ext;
      A_INSV:  reg_rdata_o = insv_ext;
      A_VEC:   reg_rdata_o[VEC_NUM_LSB +: VEC_FIELD_W] = VEC_FIELD_W'(vec_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o       = cfg_en_q && elig_any;
  assign irq_level_o = cfg_lvl_q;
  assign err_irq_o   = err_q;
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic               reg_wr_i,
  input logic [2:0]         reg_addr_i,
  input logic [31:0]        reg_wdata_i,
  input logic               irq_o,
  input logic [2:0]         irq_level_o,
  input logic               err_irq_o,
  input logic               cfg_en_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] insv_q,
  input logic [VEC_W-1:0]   vec_q
);
  logic ack_w, insv_w, cfg_w;
  logic any_ok;
  assign ack_w  = reg_wr_i && reg_addr_i == 3'd4 && reg_wdata_i[0];
  assign insv_w = reg_wr_i && reg_addr_i == 3'd3;
  assign cfg_w  = reg_wr_i && reg_addr_i == 3'd0;
  assign any_ok = (src_i & mask_q & ~insv_q) != '0;

  // R3
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en_q |-> !irq_o);

  // R4
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_w |=> irq_level_o == $past(reg_wdata_i[15:13]));

  // R6
  ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w && any_ok) |=> insv_q[vec_q]);

  // R8
  empty_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w && !any_ok) |=> (err_irq_o && vec_q == '0 && $stable(insv_q)));

  // R7
  eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insv_w |=> (insv_q & $past(reg_wdata_i[NUM_SRC-1:0])) == '0);

  // R6
  one_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_w |=> $countones(insv_q & ~$past(insv_q)) <= 1);
endmodule

bind vpic_ctrl vpic_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_i       (src_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .irq_level_o (irq_level_o),
  .err_irq_o   (err_irq_o),
  .cfg_en_q    (cfg_en_q),
  .mask_q      (mask_q),
  .insv_q      (insv_q),
  .vec_q       (vec_q)
);

// File: tb/vpic_ctrl_tb.sv
module vpic_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, err;
  logic [2:0]  lvl;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  vpic_ctrl #(.NUM_SRC(32)) u_dut (
    .clk (clk), .rst_n (rst_n), .src_i (src),
    .reg_wr_i (wr), .reg_addr_i (addr), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .irq_o (irq), .irq_level_o (lvl), .err_irq_o (err)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_src(logic [31:0] s);
    @(negedge clk);
    src = s;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rreg(3'd0, d); check("R1 cfg", d, 0);
    rreg(3'd2, d); check("R1 mask", d, 0);
    rreg(3'd3, d); check("R1 insv", d, 0);
    rreg(3'd4, d); check("R1 vec", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 err", {31'b0, err}, 0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    set_src(32'h0000_00A5);
    rreg(3'd1, d); check("R11 pend", d, 32'h0000_00A5);
    check("R2 masked no irq", {31'b0, irq}, 0);
  endtask

  task automatic t_enable_mask();
    set_src(32'h0000_0008);
    wreg(3'd2, 32'h0000_0008);
    #1; check("R3 disabled", {31'b0, irq}, 0);
    wreg(3'd0, 32'h1);
    #1; check("R9 enabled irq", {31'b0, irq}, 1);
    wreg(3'd2, 32'h0);
    #1; check("R2 mask off", {31'b0, irq}, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wreg(3'd0, 32'h0000_A001);
    #1; check("R4 level", {29'b0, lvl}, 5);
    rreg(3'd0, d); check("R4 cfg read", d, 32'h0000_A001);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    set_src(32'h4002_0008);
    wreg(3'd2, 32'hFFFF_FFFF);
    #1; check("R9 irq on", {31'b0, irq}, 1);
    wreg(3'd4, 32'h1);
    rreg(3'd4, d); check("R5 vec 30", d, 32'h0000_F000);
    rreg(3'd3, d); check("R6 insv 30", d, 32'h4000_0000);
    wreg(3'd4, 32'h1);
    rreg(3'd4, d); check("R6 vec 17", d, 32'h0000_8800);
    wreg(3'd4, 32'h1);
    rreg(3'd4, d); check("R6 vec 3", d, 32'h0000_1800);
    check("R9 all in service", {31'b0, irq}, 0);
    wreg(3'd4, 32'h1);
    rreg(3'd4, d); check("R8 empty vec", d, 0);
    rreg(3'd3, d); check("R8 insv kept", d, 32'h4002_0008);
    check("R8 err high", {31'b0, err}, 1);
    wreg(3'd3, 32'h0002_0000);
    rreg(3'd3, d); check("R7 eoi 17", d, 32'h4000_0008);
    check("R8 err held", {31'b0, err}, 1);
    wreg(3'd3, 32'h0);
    rreg(3'd3, d); check("R7 zero write", d, 32'h4000_0008);
    wreg(3'd4, 32'h1);
    rreg(3'd4, d); check("R6 re-offer 17", d, 32'h0000_8800);
    wreg(3'd4, 32'h0000_FFFE);
    rreg(3'd4, d); check("R10 no ack vec", d, 32'h0000_8800);
    rreg(3'd3, d); check("R10 no ack insv", d, 32'h4002_0008);
    wreg(3'd3, 32'hFFFF_FFFF);
    rreg(3'd3, d); check("R7 clear all", d, 0);
    check("R8 err cleared", {31'b0, err}, 0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    set_src(32'h8000_0001);
    wreg(3'd4, 32'h1);
    rreg(3'd4, d); check("R5 vec 31", d, 32'h0000_F800);
    wreg(3'd4, 32'h1);
    rreg(3'd4, d); check("R5 vec src0", d, 0);
    rreg(3'd3, d); check("R6 src0 insv", d, 32'h8000_0001);
    check("R8 src0 not error", {31'b0, err}, 0);
    wreg(3'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_race();
    logic [31:0] d;
    set_src(32'h0000_0200);
    #1; check("R9 race irq", {31'b0, irq}, 1);
    set_src(32'h0);
    wreg(3'd4, 32'h1);
    rreg(3'd4, d); check("R8 race vec", d, 0);
    rreg(3'd3, d); check("R8 race insv", d, 0);
    check("R8 race err", {31'b0, err}, 1);
    wreg(3'd3, 32'h1);
    check("R8 dismissed", {31'b0, err}, 0);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pending();
    t_enable_mask();
    t_level();
    t_priority();
    t_edges();
    t_race();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule